// File: doc/BRIEF.md
# Partitionable Secure Memory Decoder

This block sits between a processor's bus and its on-board storage. For each access it decides where the access goes. Instruction fetches and data-space (external data move) accesses arrive with an address, a fetch/data flag and a write flag. The block turns them into a select for a battery-backed RAM, a select for a clock/calendar peripheral, or an enable for the expanded external bus. It also checks the access against the protection rules. A write into the program part of RAM is blocked, and so is any fetch that would leave the board. A blocked access drives no select and raises a fault flag for one cycle.

There are two modes. In fixed mode, program space and data space are each a full 64 KB. They map onto the two halves of a 128 KB RAM, chosen by a bank bit. In partitioned mode, one 64 KB RAM is shared. Program sits below a boundary that is set in 4 KB granules, and data sits at or above it. Data reads below the boundary go to the external bus. A peripheral-enable input maps the top quarter of data space onto the clock peripheral. When the RAM is the largest configuration, a build parameter forces fixed mode. A supervisor input forces every select inactive while supply power is failing.

The decode is registered. A small state machine holds one of four states:
- `ST_IDLE`: no access.
- `ST_ACCESS`: a select is driven.
- `ST_FAULT`: a blocked access.
- `ST_FORCED`: the supervisor hold.

The machine reloads on every clock edge:
- To `ST_FORCED` when `pwr_force_off` is high.
- Otherwise, to `ST_FAULT` when a valid access is classified as blocked.
- Otherwise, to `ST_ACCESS` when an access is valid.
- Otherwise, to `ST_IDLE`.

So any state can move to any other state in one edge.

Top module: `mem_partition_decoder`

## Requirements
- R1: While reset is asserted and after it is released with no access, all selects are inactive: `ram_ce_n`=1, `rtc_cs_n`=1, `ram_we_n`=1, `ext_en`=0, `ram_bank`=0, `fault`=0.
- R2: In fixed mode (`mode_fixed`=1), a fetch selects RAM with `ram_bank`=0. A data access selects RAM with `ram_bank`=1. Data writes are allowed (`ram_we_n`=0).
- R3: In partitioned mode (`mode_fixed`=0), the boundary is `part_granule`×4096. A fetch below the boundary selects RAM with `ram_bank`=0.
- R4: In partitioned mode, a data read or write at or above the boundary selects RAM with `ram_bank`=0. A write drives `ram_we_n`=0.
- R5: In partitioned mode, a data read below the boundary drives `ext_en`=1 and no RAM select.
- R6: In partitioned mode, a data write below the boundary is blocked: `fault`=1 and no select.
- R7: In partitioned mode, a fetch at or above the boundary is blocked: `fault`=1. A fetch never drives `ext_en`.
- R8: With `periph_en`=1, a data access whose two top address bits are both 1 selects the clock peripheral (`rtc_cs_n`=0) instead of RAM, in either mode. Fetches are not affected.
- R9: When the parameter `LARGE_CFG`=1, the block behaves as fixed mode whatever `mode_fixed` is.
- R10: Results appear on the outputs in the cycle after the edge that samples `acc_valid`=1 and last one cycle. `fault` is high only for that one cycle.
- R11: When `pwr_force_off` is sampled high, the next cycle shows all selects inactive and `fault`=0, even if an access was requested.
- R12: A fetch with `acc_write`=1 is treated as a read: `ram_we_n` stays 1.
- R13: With `part_granule`=0 in partitioned mode, all of data space is RAM and every fetch is blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 16 | Access address |
| acc_is_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| acc_write | input | 1 | 1 = write (ignored for fetches) |
| mode_fixed | input | 1 | 1 = fixed mode, 0 = partitioned mode |
| periph_en | input | 1 | Maps top quarter of data space onto the clock peripheral |
| part_granule | input | 4 | Partition boundary in 4 KB units |
| pwr_force_off | input | 1 | Supervisor request to deassert every select |
| ram_ce_n | output | 1 | RAM chip enable, active low |
| ram_bank | output | 1 | RAM upper-half select (data half in fixed mode) |
| ram_we_n | output | 1 | Write strobe for RAM and peripheral, active low |
| rtc_cs_n | output | 1 | Clock peripheral select, active low |
| ext_en | output | 1 | Expanded external bus enable |
| fault | output | 1 | One-cycle protection fault |

## Verification
Every result is due exactly one register stage after its stimulus: inputs are sampled at a rising edge and the decoded selects, strobe and fault hold through the following cycle only. The bench drives each access on a falling edge, lets one rising edge pass and reads the outputs on the next falling edge, while that same falling edge presents the next access, so back-to-back decodes are checked without gaps. The supervisor hold and the return to idle are checked the same way, one cycle after the input changes.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

    typedef enum logic [2:0] {
        RG_RAM_LO,
        RG_RAM_HI,
        RG_RTC,
        RG_EXT,
        RG_BLOCK
    } region_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACCESS,
        ST_FAULT,
        ST_FORCED
    } state_e;

endpackage

// File: rtl/mdec_region.sv
module mdec_region
    import mdec_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int GRAN_W    = 4,
    parameter int RTC_W     = 2,
    parameter bit LARGE_CFG = 1'b0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_fetch,
    input  logic              is_write,
    input  logic              mode_fixed,
    input  logic              periph_en,
    input  logic [GRAN_W-1:0] granule,
    output region_e           region
);

    localparam int TOP_MSB = ADDR_W - 1;
    localparam int GRAN_LSB = ADDR_W - GRAN_W;

    logic eff_fixed;
    logic below_bound;
    logic in_rtc;

    // the largest RAM build cannot partition
    generate
        if (LARGE_CFG) begin : g_forced_fixed
            assign eff_fixed = mode_fixed | 1'b1;
        end else begin : g_selectable
            assign eff_fixed = mode_fixed;
        end
    endgenerate

    // boundary is granule-aligned, so only the top bits need comparing
    assign below_bound = addr[TOP_MSB:GRAN_LSB] < granule;
    assign in_rtc      = periph_en && (&addr[TOP_MSB -: RTC_W]);

    always_comb begin
        region = RG_EXT;
        if (is_fetch) begin
            if (eff_fixed || below_bound) region = RG_RAM_LO;
            else                          region = RG_BLOCK;
        end else if (in_rtc) begin
            region = RG_RTC;
        end else if (eff_fixed) begin
            region = RG_RAM_HI;
        end else if (!below_bound) begin
            region = RG_RAM_LO;
        end else if (is_write) begin
            region = RG_BLOCK;
        end else begin
            region = RG_EXT;
        end
    end

    // R9: the forced-fixed build never blocks a fetch
    always_comb begin
        if (LARGE_CFG && is_fetch) begin
            a_r9_no_fetch_block: assert (region == RG_RAM_LO);
        end
    end

endmodule

// File: rtl/mdec_fsm.sv
module mdec_fsm
    import mdec_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    acc_valid,
    input  logic    pwr_force_off,
    input  logic    eff_write,
    input  region_e region,
    output logic    ram_ce_n,
    output logic    ram_bank,
    output logic    ram_we_n,
    output logic    rtc_cs_n,
    output logic    ext_en,
    output logic    fault
);

    state_e  state_q, state_d;
    region_e region_q;
    logic    write_q;

    always_comb begin
        state_d = ST_IDLE;
        if (pwr_force_off)          state_d = ST_FORCED;
        else if (acc_valid)         state_d = (region == RG_BLOCK) ? ST_FAULT : ST_ACCESS;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            region_q <= RG_EXT;
            write_q  <= 1'b0;
        end else begin
            state_q  <= state_d;
            region_q <= region;
            write_q  <= eff_write;
        end
    end

    always_comb begin
        ram_ce_n = 1'b1;
        ram_bank = 1'b0;
        ram_we_n = 1'b1;
        rtc_cs_n = 1'b1;
        ext_en   = 1'b0;
        fault    = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_FORCED: begin
            end
            ST_FAULT: begin
                fault = 1'b1;
            end
            ST_ACCESS: begin
                unique case (region_q)
                    RG_RAM_LO: begin
                        ram_ce_n = 1'b0;
                        ram_we_n = ~write_q;
                    end
                    RG_RAM_HI: begin
                        ram_ce_n = 1'b0;
                        ram_bank = 1'b1;
                        ram_we_n = ~write_q;
                    end
                    RG_RTC: begin
                        rtc_cs_n = 1'b0;
                        ram_we_n = ~write_q;
                    end
                    RG_EXT: begin
                        ext_en = 1'b1;
                    end
                    default: begin
                    end
                endcase
            end
            default: begin
            end
        endcase
    end

    // R10: a fault only follows a sampled, unforced access
    a_r10_fault_from_access: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> ($past(acc_valid) && !$past(pwr_force_off)));

    // R11: supervisor hold silences everything
    a_r11_forced_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pwr_force_off) |-> (ram_ce_n && rtc_cs_n && ram_we_n && !ext_en && !fault));

    // R6: a blocked access drives no select
    a_r6_fault_no_select: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (ram_ce_n && rtc_cs_n && !ext_en && ram_we_n));

    // R10: at most one target per cycle
    a_r10_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~ram_ce_n, ~rtc_cs_n, ext_en, fault}) <= 1);

endmodule

// File: rtl/mem_partition_decoder.sv
module mem_partition_decoder
    import mdec_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int GRAN_W    = 4,
    parameter int RTC_W     = 2,
    parameter bit LARGE_CFG = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_is_fetch,
    input  logic              acc_write,
    input  logic              mode_fixed,
    input  logic              periph_en,
    input  logic [GRAN_W-1:0] part_granule,
    input  logic              pwr_force_off,
    output logic              ram_ce_n,
    output logic              ram_bank,
    output logic              ram_we_n,
    output logic              rtc_cs_n,
    output logic              ext_en,
    output logic              fault
);

    region_e region;
    logic    eff_write;

    // R12: fetches are always reads
    assign eff_write = acc_write & ~acc_is_fetch;

    mdec_region #(
        .ADDR_W    (ADDR_W),
        .GRAN_W    (GRAN_W),
        .RTC_W     (RTC_W),
        .LARGE_CFG (LARGE_CFG)
    ) u_region (
        .addr       (acc_addr),
        .is_fetch   (acc_is_fetch),
        .is_write   (eff_write),
        .mode_fixed (mode_fixed),
        .periph_en  (periph_en),
        .granule    (part_granule),
        .region     (region)
    );

    mdec_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .acc_valid     (acc_valid),
        .pwr_force_off (pwr_force_off),
        .eff_write     (eff_write),
        .region        (region),
        .ram_ce_n      (ram_ce_n),
        .ram_bank      (ram_bank),
        .ram_we_n      (ram_we_n),
        .rtc_cs_n      (rtc_cs_n),
        .ext_en        (ext_en),
        .fault         (fault)
    );

    // R7: the external bus never serves a fetch
    a_r7_fetch_never_external: assert property (@(posedge clk) disable iff (!rst_n)
        ext_en |-> !$past(acc_is_fetch));

    // R12: a write strobe only follows a data access
    a_r12_fetch_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |-> (!$past(acc_is_fetch) && $past(acc_write)));

endmodule

// File: tb/sim_mem_partition_decoder.sv
module sim_mem_partition_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [15:0] acc_addr = '0;
    logic        acc_is_fetch = 1'b0;
    logic        acc_write = 1'b0;
    logic        mode_fixed = 1'b1;
    logic        periph_en = 1'b0;
    logic [3:0]  part_granule = '0;
    logic        pwr_force_off = 1'b0;

    logic ce0, bk0, we0, rtc0, ext0, flt0;
    logic ce1, bk1, we1, rtc1, ext1, flt1;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mem_partition_decoder u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_is_fetch(acc_is_fetch), .acc_write(acc_write), .mode_fixed(mode_fixed),
        .periph_en(periph_en), .part_granule(part_granule), .pwr_force_off(pwr_force_off),
        .ram_ce_n(ce0), .ram_bank(bk0), .ram_we_n(we0), .rtc_cs_n(rtc0),
        .ext_en(ext0), .fault(flt0)
    );

    mem_partition_decoder #(.LARGE_CFG(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_is_fetch(acc_is_fetch), .acc_write(acc_write), .mode_fixed(mode_fixed),
        .periph_en(periph_en), .part_granule(part_granule), .pwr_force_off(pwr_force_off),
        .ram_ce_n(ce1), .ram_bank(bk1), .ram_we_n(we1), .rtc_cs_n(rtc1),
        .ext_en(ext1), .fault(flt1)
    );

    // outputs as {ce_n, bank, we_n, rtc_n, ext, fault}
    localparam logic [5:0] IDLE = 6'b101100;
    localparam int NV = 20;
    // {req[3:0], fetch, write, fixed, periph, gran[3:0], addr[15:0], expect[5:0]}
    localparam logic [33:0] VEC [NV] = '{
        {4'd2,  4'b1010, 4'h0, 16'h1234, 6'b001100},  // R2 fetch -> bank 0
        {4'd2,  4'b0110, 4'h0, 16'h1234, 6'b010100},  // R2 data write -> bank 1
        {4'd2,  4'b0010, 4'h0, 16'hFFFF, 6'b011100},  // R2 data read top
        {4'd3,  4'b1000, 4'h4, 16'h3FFF, 6'b001100},  // R3 fetch just below
        {4'd7,  4'b1000, 4'h4, 16'h4000, 6'b101101},  // R7 fetch at boundary
        {4'd4,  4'b0100, 4'h4, 16'h4000, 6'b000100},  // R4 write at boundary
        {4'd4,  4'b0000, 4'h4, 16'hBEEF, 6'b001100},  // R4 read above
        {4'd5,  4'b0000, 4'h4, 16'h3FFF, 6'b101110},  // R5 read below -> ext
        {4'd6,  4'b0100, 4'h4, 16'h0000, 6'b101101},  // R6 write below blocked
        {4'd8,  4'b0111, 4'h4, 16'hC000, 6'b100000},  // R8 fixed rtc write
        {4'd8,  4'b0001, 4'h4, 16'hFFFF, 6'b101000},  // R8 partitioned rtc read
        {4'd8,  4'b1011, 4'h0, 16'hC000, 6'b001100},  // R8 fetch unaffected
        {4'd8,  4'b0011, 4'h0, 16'hBFFF, 6'b011100},  // R8 just below rtc window
        {4'd8,  4'b0101, 4'hF, 16'hC000, 6'b100000},  // R8 rtc over program region
        {4'd12, 4'b1110, 4'h0, 16'h0010, 6'b001100},  // R12 fetch with write flag
        {4'd12, 4'b1100, 4'h8, 16'h0010, 6'b001100},  // R12 partitioned fetch+write
        {4'd13, 4'b1000, 4'h0, 16'h0000, 6'b101101},  // R13 gran 0 fetch blocked
        {4'd13, 4'b0100, 4'h0, 16'h0000, 6'b000100},  // R13 gran 0 data write
        {4'd3,  4'b1000, 4'hF, 16'hEFFF, 6'b001100},  // R3 largest boundary
        {4'd7,  4'b1000, 4'hF, 16'hF000, 6'b101101}   // R7 beyond largest boundary
    };

    task automatic check(input string tag, input logic [5:0] got, input logic [5:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%b expected=%b", tag, got, exp);
        end
    endtask

    task automatic drive(input logic f, input logic w, input logic fx, input logic p,
                         input logic [3:0] g, input logic [15:0] a);
        acc_valid = 1'b1; acc_is_fetch = f; acc_write = w; mode_fixed = fx;
        periph_en = p; part_granule = g; acc_addr = a;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 in reset", {ce0, bk0, we0, rtc0, ext0, flt0}, IDLE);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 after release", {ce0, bk0, we0, rtc0, ext0, flt0}, IDLE);

        // vector table, back to back, one cycle latency
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][29], VEC[i][28], VEC[i][27], VEC[i][26], VEC[i][25:22], VEC[i][21:6]);
            @(posedge clk);
            @(negedge clk);
            check($sformatf("R%0d vec%0d", VEC[i][33:30], i),
                  {ce0, bk0, we0, rtc0, ext0, flt0}, VEC[i][5:0]);
        end

        // R10: fault lasts one cycle then idle
        drive(1'b0, 1'b1, 1'b0, 1'b0, 4'h4, 16'h0100);
        @(negedge clk);
        check("R10 fault raised", {ce0, bk0, we0, rtc0, ext0, flt0}, 6'b101101);
        acc_valid = 1'b0;
        @(negedge clk);
        check("R10 fault cleared", {ce0, bk0, we0, rtc0, ext0, flt0}, IDLE);

        // R10: access shows for one cycle only
        drive(1'b0, 1'b0, 1'b0, 1'b0, 4'h4, 16'h8000);
        @(negedge clk);
        check("R10 access shown", {ce0, bk0, we0, rtc0, ext0, flt0}, 6'b001100);
        acc_valid = 1'b0;
        @(negedge clk);
        check("R10 back to idle", {ce0, bk0, we0, rtc0, ext0, flt0}, IDLE);

        // R11: supervisor hold overrides a valid write and a blocked access
        drive(1'b0, 1'b1, 1'b1, 1'b0, 4'h0, 16'h2000);
        pwr_force_off = 1'b1;
        @(negedge clk);
        check("R11 forced write", {ce0, bk0, we0, rtc0, ext0, flt0}, IDLE);
        drive(1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 16'h2000);
        @(negedge clk);
        check("R11 forced no fault", {ce0, bk0, we0, rtc0, ext0, flt0}, IDLE);
        pwr_force_off = 1'b0;
        drive(1'b0, 1'b1, 1'b1, 1'b0, 4'h0, 16'h2000);
        @(negedge clk);
        check("R11 release resumes", {ce0, bk0, we0, rtc0, ext0, flt0}, 6'b010100);

        // R9: large build ignores the mode bit
        drive(1'b0, 1'b1, 1'b0, 1'b0, 4'h4, 16'h0000);
        @(negedge clk);
        check("R9 large data write", {ce1, bk1, we1, rtc1, ext1, flt1}, 6'b010100);
        check("R6 small build same access", {ce0, bk0, we0, rtc0, ext0, flt0}, 6'b101101);
        drive(1'b1, 1'b0, 1'b0, 1'b0, 4'h4, 16'hF000);
        @(negedge clk);
        check("R9 large fetch high", {ce1, bk1, we1, rtc1, ext1, flt1}, 6'b001100);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 4'h4, 16'h1000);
        @(negedge clk);
        check("R9 large no ext", {ce1, bk1, we1, rtc1, ext1, flt1}, 6'b011100);
        acc_valid = 1'b0;
        @(negedge clk);
        check("R1 idle at end", {ce0, bk0, we0, rtc0, ext0, flt0}, IDLE);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule